// File: doc/BRIEF.md
# Loss-of-Signal Detector

This block decides whether a received line has lost its signal. Once per bit interval a strobe arrives together with a flag that says whether a pulse above the amplitude threshold was seen in that interval. While the line is healthy the block counts consecutive intervals with no pulse and declares loss of signal when that run reaches a declare limit. While loss is declared it waits for a pulse. It then opens a clear window of fixed length that begins on that pulse, counts the pulses inside it, and drops the loss indication only if the window holds at least one eighth as many pulses as it has intervals.

Two inputs choose the limits. One selects E1 or T1/J1 line rates and the other selects a short or a long criteria set. The declare event raises a one-cycle interrupt pulse unless a mask input is set. The block also holds a 5-bit amplitude threshold code that is written from outside and read back. It does not interpret that code. Amplitude comparison itself takes place upstream of this block.

Top module: `los_detector`

## Requirements
- R1: With no loss declared, `los` rises after the strobed interval that completes N consecutive empty intervals. N is 32 for E1 (`e1_mode`=1) with `crit_sel`=0, 175 for T1/J1 (`e1_mode`=0) with `crit_sel`=0, and 2048 for either rate with `crit_sel`=1.
- R2: A strobed interval with `pulse_seen`=1 restarts the consecutive-empty count from zero.
- R3: Cycles with `bit_stb`=0 are ignored whatever `pulse_seen` shows, so they neither advance nor reset any count.
- R4: With loss declared, `los` falls after the last interval of an M-interval clear window that contains at least ceil(M/8) pulses. M equals N for the same selection, which gives 4 of 32, 22 of 175 and 256 of 2048.
- R5: A clear window opens only on a strobed interval that carries a pulse. Empty intervals before that pulse do not count toward M.
- R6: A window that ends with too few pulses leaves `los` high. The next window opens on the next pulse after it ends.
- R7: `los_irq` is high for exactly the one cycle in which `los` first reads 1 after a declare, and only if `irq_mask` was 0 on the declaring interval. Otherwise `los_irq` stays 0.
- R8: `thr_code` resets to 5'b10101, loads `thr_din` on a cycle with `thr_we`=1, and holds its value otherwise.
- R9: During and after synchronous reset (`rst_n`=0), `los` and `los_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One bit interval has ended |
| pulse_seen | input | 1 | A pulse above threshold was seen in the strobed interval |
| e1_mode | input | 1 | 1 selects E1 limits, 0 selects T1/J1 limits |
| crit_sel | input | 1 | 0 selects the short criteria set, 1 selects the long set |
| irq_mask | input | 1 | Suppresses the declare interrupt |
| thr_we | input | 1 | Write strobe for the threshold code |
| thr_din | input | 5 | New threshold code |
| los | output | 1 | Loss of signal indication |
| los_irq | output | 1 | One-cycle declare interrupt |
| thr_code | output | 5 | Stored threshold code |

## Verification
Empty runs one interval short of the limit and runs exactly at the limit are applied for every rate and criteria combination. These runs show whether each limit is decoded correctly. Clear patterns place a pulse every 8th, 9th or 11th interval, and some of them stop one interval early. This separates a window that just meets the density figure from one that falls short and from one that ends too soon. Further tests place a pulse in the middle of an empty run, idle cycles with a high pulse flag, and empty intervals before the first clearing pulse. These show whether the count restarts correctly, whether unstrobed cycles leak into the counts, and whether the window is anchored on a pulse.

// File: rtl/los_pkg.sv
// Package: shared helpers for the loss-of-signal detector.
// Assumes: window lengths are positive integers.
package los_pkg;

    typedef enum logic {
        CRIT_SHORT = 1'b0,
        CRIT_LONG  = 1'b1
    } crit_e;

    // Minimum pulses for a 12.5 % density over a window of m intervals.
    function automatic int unsigned min_pulses(input int unsigned m);
        return (m + 7) / 8;
    endfunction

endpackage

// File: rtl/los_limit_sel.sv
// Module: los_limit_sel
// Picks the declare length, the clear window length and the minimum pulse
// count from the rate and criteria selections.
// Assumes: all lengths fit in CW bits; selections are quasi-static.
module los_limit_sel #(
    parameter int unsigned CW       = 12,
    parameter int unsigned E1_N_S   = 32,
    parameter int unsigned E1_M_S   = 32,
    parameter int unsigned T1_N_S   = 175,
    parameter int unsigned T1_M_S   = 175,
    parameter int unsigned E1_N_L   = 2048,
    parameter int unsigned E1_M_L   = 2048,
    parameter int unsigned T1_N_L   = 2048,
    parameter int unsigned T1_M_L   = 2048
) (
    input  logic          e1_mode,
    input  logic          crit_sel,
    output logic [CW-1:0] n_lim,
    output logic [CW-1:0] m_lim,
    output logic [CW-1:0] p_min
);
    import los_pkg::*;

    localparam logic [CW-1:0] PE1S = CW'(min_pulses(E1_M_S));
    localparam logic [CW-1:0] PT1S = CW'(min_pulses(T1_M_S));
    localparam logic [CW-1:0] PE1L = CW'(min_pulses(E1_M_L));
    localparam logic [CW-1:0] PT1L = CW'(min_pulses(T1_M_L));

    crit_e crit;
    assign crit = crit_e'(crit_sel);

    // Decode the four limit sets.
    always_comb begin
        if (crit == CRIT_SHORT) begin
            n_lim = e1_mode ? CW'(E1_N_S) : CW'(T1_N_S);
            m_lim = e1_mode ? CW'(E1_M_S) : CW'(T1_M_S);
            p_min = e1_mode ? PE1S : PT1S;
        end else begin
            n_lim = e1_mode ? CW'(E1_N_L) : CW'(T1_N_L);
            m_lim = e1_mode ? CW'(E1_M_L) : CW'(T1_M_L);
            p_min = e1_mode ? PE1L : PT1L;
        end
    end

endmodule

// File: rtl/los_declare_cnt.sv
// Module: los_declare_cnt
// Counts consecutive strobed intervals without a pulse and flags the
// interval that completes n_lim of them.
// Assumes: en is low while loss is declared; the count is then held at zero.
module los_declare_cnt #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb,
    input  logic          pulse,
    input  logic [CW-1:0] n_lim,
    output logic          hit
);
    logic [CW-1:0] zcnt;
    logic          last;

    assign last = (zcnt + CW'(1)) >= n_lim;
    assign hit  = en && stb && !pulse && last;

    // Advance, restart or clear the empty-interval run.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            zcnt <= '0;
        end else if (stb) begin
            if (pulse || last) zcnt <= '0;
            else               zcnt <= zcnt + CW'(1);
        end
    end

    // R2: a pulse in a strobed interval restarts the run.
    p_pulse_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && pulse) |=> (zcnt == '0));

    // R3: an unstrobed cycle leaves the run unchanged.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !stb) |=> (!en || zcnt == $past(zcnt)));

endmodule

// File: rtl/los_clear_win.sv
// Module: los_clear_win
// Opens a window of m_lim strobed intervals on a pulse and reports, on the
// last interval, whether at least p_min pulses were seen in it.
// Assumes: en is high only while loss is declared.
module los_clear_win #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb,
    input  logic          pulse,
    input  logic [CW-1:0] m_lim,
    input  logic [CW-1:0] p_min,
    output logic          ok
);
    logic          active;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] pcnt;
    logic [CW-1:0] wnext;
    logic [CW-1:0] pnext;
    logic          at_end;

    assign wnext  = wcnt + CW'(1);
    assign pnext  = pcnt + CW'(pulse);
    assign at_end = wnext >= m_lim;
    assign ok     = en && stb && active && at_end && (pnext >= p_min);

    // Open the window on a pulse, then count intervals and pulses to its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active <= 1'b0;
            wcnt   <= '0;
            pcnt   <= '0;
        end else if (stb) begin
            if (!active) begin
                active <= pulse;
                wcnt   <= CW'(1);
                pcnt   <= CW'(1);
            end else if (at_end) begin
                active <= 1'b0;
                wcnt   <= '0;
                pcnt   <= '0;
            end else begin
                wcnt   <= wnext;
                pcnt   <= pnext;
            end
        end
    end

    // R5: without a strobed pulse an idle window stays idle.
    p_open_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(stb && pulse)) |=> !active);

    // R4: the pulse count never exceeds the interval count.
    p_pulses_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pcnt <= wcnt));

endmodule

// File: rtl/los_detector.sv
// Module: los_detector (top)
// Declares loss of signal after a run of empty bit intervals and clears it
// after a pulse-anchored window of sufficient pulse density. It raises a
// maskable one-cycle interrupt on declare and holds a threshold code.
// Assumes: pulse_seen already reflects the amplitude threshold in force.
module los_detector #(
    parameter int unsigned    E1_N_S  = 32,
    parameter int unsigned    E1_M_S  = 32,
    parameter int unsigned    T1_N_S  = 175,
    parameter int unsigned    T1_M_S  = 175,
    parameter int unsigned    E1_N_L  = 2048,
    parameter int unsigned    E1_M_L  = 2048,
    parameter int unsigned    T1_N_L  = 2048,
    parameter int unsigned    T1_M_L  = 2048,
    parameter int unsigned    THR_W   = 5,
    parameter logic [THR_W-1:0] THR_RST = 5'b10101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             pulse_seen,
    input  logic             e1_mode,
    input  logic             crit_sel,
    input  logic             irq_mask,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_din,
    output logic             los,
    output logic             los_irq,
    output logic [THR_W-1:0] thr_code
);
    localparam int unsigned MAX_S = (E1_N_S > T1_N_S) ? E1_N_S : T1_N_S;
    localparam int unsigned MAX_T = (E1_M_S > T1_M_S) ? E1_M_S : T1_M_S;
    localparam int unsigned MAX_U = (E1_N_L > T1_N_L) ? E1_N_L : T1_N_L;
    localparam int unsigned MAX_V = (E1_M_L > T1_M_L) ? E1_M_L : T1_M_L;
    localparam int unsigned MAX_A = (MAX_S > MAX_T) ? MAX_S : MAX_T;
    localparam int unsigned MAX_B = (MAX_U > MAX_V) ? MAX_U : MAX_V;
    localparam int unsigned MAXL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW    = $clog2(MAXL + 1);

    logic [CW-1:0] n_lim;
    logic [CW-1:0] m_lim;
    logic [CW-1:0] p_min;
    logic          decl_hit;
    logic          clr_ok;

    los_limit_sel #(
        .CW(CW),
        .E1_N_S(E1_N_S), .E1_M_S(E1_M_S), .T1_N_S(T1_N_S), .T1_M_S(T1_M_S),
        .E1_N_L(E1_N_L), .E1_M_L(E1_M_L), .T1_N_L(T1_N_L), .T1_M_L(T1_M_L)
    ) u_lim (
        .e1_mode (e1_mode),
        .crit_sel(crit_sel),
        .n_lim   (n_lim),
        .m_lim   (m_lim),
        .p_min   (p_min)
    );

    los_declare_cnt #(.CW(CW)) u_decl (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (!los),
        .stb  (bit_stb),
        .pulse(pulse_seen),
        .n_lim(n_lim),
        .hit  (decl_hit)
    );

    los_clear_win #(.CW(CW)) u_clr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (los),
        .stb  (bit_stb),
        .pulse(pulse_seen),
        .m_lim(m_lim),
        .p_min(p_min),
        .ok   (clr_ok)
    );

    // Loss state: set on declare, cleared on a good window.
    always_ff @(posedge clk) begin
        if (!rst_n)    los <= 1'b0;
        else if (los)  los <= !clr_ok;
        else           los <= decl_hit;
    end

    // One-cycle interrupt on declare, gated by the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) los_irq <= 1'b0;
        else        los_irq <= decl_hit && !irq_mask;
    end

    // Threshold code holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_code <= THR_RST;
        else if (thr_we) thr_code <= thr_din;
    end

    // R1: a declare follows a strobed empty interval.
    p_declare_on_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(bit_stb && !pulse_seen));

    // R4: a clear follows a strobed interval.
    p_clear_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(bit_stb));

    // R7: interrupt matches a declare and the mask.
    p_irq_on_declare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> (los_irq == !$past(irq_mask)));
    p_irq_only_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        los_irq |-> $rose(los));

    // R8: the code changes only after a write.
    p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(thr_we) |-> $stable(thr_code));

endmodule

// File: tb/tb_los_detector.sv
// Bench for los_detector: a vector table from reset, then directed tests.
module tb_los_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       pulse_seen = 1'b0;
    logic       e1_mode = 1'b1;
    logic       crit_sel = 1'b0;
    logic       irq_mask = 1'b0;
    logic       thr_we = 1'b0;
    logic [4:0] thr_din = 5'd0;
    logic       los;
    logic       los_irq;
    logic [4:0] thr_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    los_detector dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pulse_seen(pulse_seen),
        .e1_mode(e1_mode), .crit_sel(crit_sel), .irq_mask(irq_mask),
        .thr_we(thr_we), .thr_din(thr_din),
        .los(los), .los_irq(los_irq), .thr_code(thr_code)
    );

    typedef struct packed {
        logic        e1;
        logic        crit;
        logic [15:0] empties;
        logic        exp_decl;
        logic [15:0] clr_len;
        logic [7:0]  clr_gap;
        logic        exp_end;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 16'd31,   1'b0, 16'd0,    8'd1,  1'b0},
        '{1'b1, 1'b0, 16'd32,   1'b1, 16'd32,   8'd8,  1'b0},
        '{1'b1, 1'b0, 16'd32,   1'b1, 16'd31,   8'd8,  1'b1},
        '{1'b1, 1'b0, 16'd32,   1'b1, 16'd32,   8'd11, 1'b1},
        '{1'b0, 1'b0, 16'd174,  1'b0, 16'd0,    8'd1,  1'b0},
        '{1'b0, 1'b0, 16'd175,  1'b1, 16'd175,  8'd8,  1'b0},
        '{1'b0, 1'b0, 16'd175,  1'b1, 16'd175,  8'd9,  1'b1},
        '{1'b1, 1'b1, 16'd2047, 1'b0, 16'd0,    8'd1,  1'b0},
        '{1'b1, 1'b1, 16'd2048, 1'b1, 16'd2048, 8'd8,  1'b0},
        '{1'b0, 1'b1, 16'd2048, 1'b1, 16'd2048, 8'd9,  1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_stb = 1'b0; pulse_seen = 1'b0; thr_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic interval(input logic p);
        @(negedge clk);
        bit_stb = 1'b1;
        pulse_seen = p;
    endtask

    task automatic idle(input logic p);
        @(negedge clk);
        bit_stb = 1'b0;
        pulse_seen = p;
    endtask

    task automatic empties(input int k);
        for (int i = 0; i < k; i++) interval(1'b0);
    endtask

    task automatic clear_pat(input int len, input int gap);
        for (int i = 0; i < len; i++) interval((i % gap) == 0);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R9 / R8: state held during reset and just after it.
        repeat (2) @(negedge clk);
        check("R9 los in reset", {7'd0, los}, 8'd0);
        check("R9 irq in reset", {7'd0, los_irq}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 los after reset", {7'd0, los}, 8'd0);
        check("R8 threshold reset code", {3'd0, thr_code}, 8'h15);

        // R1 R4 R6: vector table, each entry from reset.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            e1_mode = VECS[v].e1;
            crit_sel = VECS[v].crit;
            irq_mask = 1'b0;
            empties(int'(VECS[v].empties));
            idle(1'b0);
            check($sformatf("R1 declare vec %0d", v), {7'd0, los}, {7'd0, VECS[v].exp_decl});
            clear_pat(int'(VECS[v].clr_len), int'(VECS[v].clr_gap));
            idle(1'b0);
            check($sformatf("R4 R6 clear vec %0d", v), {7'd0, los}, {7'd0, VECS[v].exp_end});
        end

        // R8: write then hold.
        do_reset();
        @(negedge clk); thr_we = 1'b1; thr_din = 5'b00011;
        @(negedge clk); thr_we = 1'b0; thr_din = 5'b11100;
        check("R8 threshold write", {3'd0, thr_code}, 8'h03);
        @(negedge clk);
        check("R8 threshold hold", {3'd0, thr_code}, 8'h03);

        // R2: pulse mid-run restarts the empty count.
        do_reset();
        e1_mode = 1'b1; crit_sel = 1'b0;
        empties(20); interval(1'b1); empties(31); idle(1'b0);
        check("R2 no declare after restart", {7'd0, los}, 8'd0);
        empties(1); idle(1'b0);
        check("R2 declare after full run", {7'd0, los}, 8'd1);

        // R3: unstrobed cycles with the pulse flag high are ignored.
        do_reset();
        empties(31);
        for (int i = 0; i < 5; i++) idle(1'b1);
        check("R3 no declare on idle", {7'd0, los}, 8'd0);
        empties(1); idle(1'b0);
        check("R3 idle pulse ignored", {7'd0, los}, 8'd1);

        // R7: interrupt pulse when unmasked.
        do_reset();
        irq_mask = 1'b0;
        empties(32); idle(1'b0);
        check("R7 irq on declare", {7'd0, los_irq}, 8'd1);
        idle(1'b0);
        check("R7 irq one cycle", {7'd0, los_irq}, 8'd0);

        // R7: interrupt suppressed when masked.
        do_reset();
        irq_mask = 1'b1;
        empties(32); idle(1'b0);
        check("R7 los with mask", {7'd0, los}, 8'd1);
        check("R7 irq masked", {7'd0, los_irq}, 8'd0);
        irq_mask = 1'b0;

        // R5: empty intervals before the first pulse do not open the window.
        do_reset();
        empties(32); empties(5);
        clear_pat(31, 8); idle(1'b0);
        check("R5 window not yet complete", {7'd0, los}, 8'd1);
        interval(1'b0); idle(1'b0);
        check("R5 window anchored on pulse", {7'd0, los}, 8'd0);

        // R6: a failed window restarts on the next pulse.
        do_reset();
        empties(32);
        clear_pat(32, 11); empties(3);
        clear_pat(31, 8); idle(1'b0);
        check("R6 second window incomplete", {7'd0, los}, 8'd1);
        interval(1'b0); idle(1'b0);
        check("R6 second window clears", {7'd0, los}, 8'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule